// File: doc/BRIEF.md
# Cache Way Shrink/Expand Controller

This controller decides how many ways of a shared last-level cache stay enabled in a package with two cores. It tracks each core's idle level and the hint that came with the core's last idle request. Each time the whole package moves into deep idle, it shrinks the cache by one way. A special hint shrinks every remaining way in a single step. Once no ways are left, the controller permits deep package sleep.

On a wake event the cache grows back. Leaving deepest package sleep normally restores two ways. If something happened since the last wake that calls for full performance, the next wake restores every way instead. Disabling a way is a handshake: the controller raises a flush request for that way, and the way stays enabled until its flush-done acknowledge arrives. A prevention bit in the idle hint blocks all shrinking and keeps the package out of deep sleep.

Top module: `way_gate_ctrl`

## Requirements
- R1: After reset all ways are enabled, and `flush_req`, `inval` and `deep_ok` are all zero.
- R2: Idle levels are encoded as 0 = active, 1..3 = shallow, 4 = core deep idle and 5 = deepest; 6 and 7 count as deep idle. When a request makes both cores deep idle (level 4 or more) and nothing prevents shrinking, `flush_req` rises on the next clock for the single highest-index enabled way.
- R3: A way's `way_en` bit clears only in the cycle after its `flush_done` bit is sampled while its `flush_req` is high. A `flush_done` bit for a way that has no pending request has no effect.
- R4: If the request that completes package deep idle is level 5 with hint value 0x2, `flush_req` covers all enabled ways at once.
- R5: `deep_ok` is high exactly when both cores are deep idle, no core holds prevention and no way is enabled. A wake event drops it.
- R6: A deep-idle request whose hint bit 0 is 1 sets prevention for that core. While prevention is held, no shrink starts and `deep_ok` stays low. The core's next request or a wake of that core clears its prevention.
- R7: A wake while `deep_ok` is high enables ways 0 and 1. `inval` pulses for one cycle on exactly those ways, in the same cycle the ways become enabled.
- R8: Expand-all is armed by any of three events: a `ratio_vld` pulse whose ratio is strictly above the threshold, `timer_exp`, or a core request for level 1..3. The next wake then enables every way, pulses `inval` on the ways that were disabled, cancels pending flushes and disarms.
- R9: When expand-all is armed and `deep_ok` is high on the same wake, all ways are enabled rather than two.
- R10: After a two-way expand, later package deep-idle entries shrink the cache again, one way per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_req_vld | input | 2 | Per-core idle request strobe |
| core_req_lvl | input | 6 | Requested level, 3 bits per core |
| core_req_hint | input | 8 | Sub-state hint, 4 bits per core |
| wake | input | 1 | Interrupt/wake event |
| wake_core | input | 1 | Core that the wake returns to active |
| ratio_vld | input | 1 | Performance-ratio request strobe |
| ratio_val | input | RW | Requested ratio |
| shrink_thr | input | RW | Ratio threshold for expand-all |
| timer_exp | input | 1 | Active-time timer expiry |
| flush_done | input | NWAYS | Per-way flush acknowledge |
| way_en | output | NWAYS | Enabled-way mask |
| flush_req | output | NWAYS | Per-way flush request, held until acknowledged |
| inval | output | NWAYS | One-cycle invalidate on re-enabled ways |
| deep_ok | output | 1 | Deep package sleep permitted |

## Verification
A corrupted core-level or prevention register shows up at the ports in the cycle after the next request. The symptom is a flush request that should not appear, or one that is missing, and `deep_ok` disagrees as well once the mask is empty. A stale expand-all flag becomes visible only on the following wake, where `way_en` jumps to all ones instead of staying put or showing two ways. An error in the flush bookkeeping shows up as `way_en` bits that clear without a matching acknowledge, or that never clear, one cycle after the acknowledge is sampled.

// File: rtl/way_gate_ctrl.sv
module way_gate_ctrl #(
  parameter int NWAYS = 8,
  parameter int RW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       core_req_vld,
  input  logic [5:0]       core_req_lvl,
  input  logic [7:0]       core_req_hint,
  input  logic             wake,
  input  logic             wake_core,
  input  logic             ratio_vld,
  input  logic [RW-1:0]    ratio_val,
  input  logic [RW-1:0]    shrink_thr,
  input  logic             timer_exp,
  input  logic [NWAYS-1:0] flush_done,
  output logic [NWAYS-1:0] way_en,
  output logic [NWAYS-1:0] flush_req,
  output logic [NWAYS-1:0] inval,
  output logic             deep_ok
);

  localparam logic [NWAYS-1:0] ALL = {NWAYS{1'b1}};
  localparam logic [NWAYS-1:0] TWO = {{(NWAYS-2){1'b0}}, 2'b11};
  localparam logic [2:0] LVL_DEEP = 3'd4;
  localparam logic [2:0] LVL_MAX  = 3'd5;
  localparam logic [3:0] HINT_FULL = 4'h2;

  logic [1:0][2:0]   lvl_q, lvl_d;
  logic [1:0]        prev_q, prev_d;
  logic              arm_q, arm_d;
  logic [NWAYS-1:0]  en_q, en_d, pend_q, pend_d, inval_q, ack;
  logic              full_hit, arm_ev, pkg_q, pkg_d, enter;

  function automatic logic [NWAYS-1:0] top_way(input logic [NWAYS-1:0] m);
    logic [NWAYS-1:0] r;
    r = '0;
    for (int i = 0; i < NWAYS; i++)
      if (m[i]) r = NWAYS'(1) << i;
    return r;
  endfunction

  assign pkg_q   = (lvl_q[0] >= LVL_DEEP) && (lvl_q[1] >= LVL_DEEP);
  assign deep_ok = pkg_q && (prev_q == 2'b00) && (en_q == '0);

  always_comb begin
    lvl_d    = lvl_q;
    prev_d   = prev_q;
    full_hit = 1'b0;
    arm_ev   = 1'b0;
    for (int c = 0; c < 2; c++) begin
      if (core_req_vld[c]) begin
        lvl_d[c]  = core_req_lvl[c*3 +: 3];
        prev_d[c] = (core_req_lvl[c*3 +: 3] >= LVL_DEEP) && core_req_hint[c*4];
        if (core_req_lvl[c*3 +: 3] == LVL_MAX && core_req_hint[c*4 +: 4] == HINT_FULL)
          full_hit = 1'b1;
        if (core_req_lvl[c*3 +: 3] != 3'd0 && core_req_lvl[c*3 +: 3] < LVL_DEEP)
          arm_ev = 1'b1;
      end
    end
    if (wake) begin
      lvl_d[wake_core]  = 3'd0;
      prev_d[wake_core] = 1'b0;
    end
  end

  assign pkg_d = (lvl_d[0] >= LVL_DEEP) && (lvl_d[1] >= LVL_DEEP);
  assign enter = pkg_d && !pkg_q;
  assign ack   = flush_done & pend_q;

  always_comb begin
    en_d   = en_q & ~ack;
    pend_d = pend_q & ~ack;
    if (wake && arm_q) begin
      en_d   = ALL;
      pend_d = '0;
    end else if (wake && deep_ok) begin
      en_d = en_d | TWO;
    end else if (enter && (prev_d == 2'b00) && (pend_q == '0)) begin
      pend_d = full_hit ? en_q : top_way(en_q);
    end
  end

  assign arm_d = wake ? 1'b0
               : (arm_q | arm_ev | timer_exp | (ratio_vld && (ratio_val > shrink_thr)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      prev_q  <= '0;
      arm_q   <= 1'b0;
      en_q    <= ALL;
      pend_q  <= '0;
      inval_q <= '0;
    end else begin
      lvl_q   <= lvl_d;
      prev_q  <= prev_d;
      arm_q   <= arm_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
      inval_q <= en_d & ~en_q;
    end
  end

  assign way_en    = en_q;
  assign flush_req = pend_q;
  assign inval     = inval_q;

  // R3: flushes are requested only on enabled ways
  assert_flush_on_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req & ~way_en) == '0);

  // R3: an enable bit clears only after an acknowledged request
  assert_clear_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~way_en & $past(way_en)) & ~$past(flush_done & flush_req)) == '0);

  assert_inval_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inval != '0) |-> ((inval & $past(way_en)) == '0));

  assert_deep_no_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    deep_ok |-> (flush_req == '0));

  assert_expand_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && arm_q) |=> (way_en == ALL && flush_req == '0));

endmodule

// File: tb/way_gate_ctrl_bench.sv
`timescale 1ns/1ps
module way_gate_ctrl_bench;
  localparam int NW = 8;
  localparam int RW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] core_req_vld = '0;
  logic [5:0] core_req_lvl = '0;
  logic [7:0] core_req_hint = '0;
  logic wake = 1'b0, wake_core = 1'b0, ratio_vld = 1'b0, timer_exp = 1'b0;
  logic [RW-1:0] ratio_val = '0, shrink_thr = 8'd20;
  logic [NW-1:0] flush_done = '0;
  logic [NW-1:0] way_en, flush_req, inval;
  logic deep_ok;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  way_gate_ctrl #(.NWAYS(NW), .RW(RW)) u_way_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .core_req_vld(core_req_vld), .core_req_lvl(core_req_lvl),
    .core_req_hint(core_req_hint), .wake(wake), .wake_core(wake_core),
    .ratio_vld(ratio_vld), .ratio_val(ratio_val), .shrink_thr(shrink_thr),
    .timer_exp(timer_exp), .flush_done(flush_done), .way_en(way_en),
    .flush_req(flush_req), .inval(inval), .deep_ok(deep_ok));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic req(input int c, input int lvl, input int hint);
    @(negedge clk);
    core_req_vld[c] = 1'b1;
    core_req_lvl[c*3 +: 3] = 3'(lvl);
    core_req_hint[c*4 +: 4] = 4'(hint);
    @(negedge clk);
    core_req_vld = '0;
  endtask

  task automatic ack(input logic [NW-1:0] m);
    @(negedge clk); flush_done = m;
    @(negedge clk); flush_done = '0;
  endtask

  task automatic wk(input int c);
    @(negedge clk); wake = 1'b1; wake_core = c[0];
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "way_en", way_en, 8'hff);
    chk("R1", "flush_req", flush_req, 0);
    chk("R1", "inval", inval, 0);
    chk("R1", "deep_ok", deep_ok, 0);
  endtask

  task automatic t_incremental;
    req(0, 4, 0);
    chk("R2", "one core deep: no flush", flush_req, 0);
    req(1, 4, 0);
    chk("R2", "top way flush", flush_req, 8'h80);
    ack(8'h01);
    chk("R3", "stray ack ignored", way_en, 8'hff);
    ack(8'h80);
    chk("R3", "way 7 cleared", way_en, 8'h7f);
    chk("R3", "request dropped", flush_req, 0);
    wk(0);
    chk("R2", "plain wake keeps mask", way_en, 8'h7f);
    req(0, 4, 0);
    chk("R2", "next entry flushes way 6", flush_req, 8'h40);
    ack(8'h40);
    chk("R2", "mask after second step", way_en, 8'h3f);
  endtask

  task automatic t_full_and_expand;
    wk(1);
    req(1, 5, 2);
    chk("R4", "full shrink request", flush_req, 8'h3f);
    chk("R5", "no permit while flushing", deep_ok, 0);
    ack(8'h3f);
    chk("R4", "mask empty", way_en, 0);
    chk("R5", "deep permitted", deep_ok, 1);
    wk(0);
    chk("R7", "two ways back", way_en, 8'h03);
    chk("R7", "inval on two ways", inval, 8'h03);
    chk("R5", "permit dropped on wake", deep_ok, 0);
    @(negedge clk);
    chk("R7", "inval one cycle", inval, 0);
  endtask

  task automatic t_prevent_and_reshrink;
    req(0, 4, 1);
    chk("R6", "prevented: no flush", flush_req, 0);
    chk("R6", "prevented: no permit", deep_ok, 0);
    chk("R6", "prevented: mask kept", way_en, 8'h03);
    wk(0);
    req(0, 4, 0);
    chk("R10", "reshrink top of two", flush_req, 8'h02);
    ack(8'h02);
    chk("R10", "one way left", way_en, 8'h01);
    wk(0);
  endtask

  task automatic t_arm_sources;
    @(negedge clk); ratio_vld = 1'b1; ratio_val = 8'd20;
    @(negedge clk); ratio_vld = 1'b0;
    wk(0);
    chk("R8", "ratio equal threshold: no expand", way_en, 8'h01);
    @(negedge clk); ratio_vld = 1'b1; ratio_val = 8'd21;
    @(negedge clk); ratio_vld = 1'b0;
    wk(0);
    chk("R8", "ratio expand-all mask", way_en, 8'hff);
    chk("R8", "ratio expand-all inval", inval, 8'hfe);
  endtask

  task automatic t_priority;
    req(0, 5, 2);
    chk("R4", "full shrink all eight", flush_req, 8'hff);
    ack(8'hff);
    chk("R5", "deep permitted again", deep_ok, 1);
    @(negedge clk); timer_exp = 1'b1;
    @(negedge clk); timer_exp = 1'b0;
    wk(0);
    chk("R9", "expand-all wins over two", way_en, 8'hff);
    chk("R9", "inval all ways", inval, 8'hff);
  endtask

  task automatic t_shallow_cancel;
    req(0, 4, 0);
    chk("R2", "flush pending", flush_req, 8'h80);
    req(1, 2, 0);
    wk(1);
    chk("R8", "pending flush cancelled", flush_req, 0);
    chk("R8", "mask full", way_en, 8'hff);
    chk("R8", "no inval when nothing re-enabled", inval, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_incremental();
    t_full_and_expand();
    t_prevent_and_reshrink();
    t_arm_sources();
    t_priority();
    t_shallow_cancel();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule